// File: doc/BRIEF.md
# Transmit Tag Insert and VLAN Strip Editor

This block sits in a byte-wide transmit stream and rewrites each frame on the fly. It uses a valid/ready handshake on both sides. After the two 6-byte MAC addresses it can place a tag sequence of 4, 6 or 10 bytes. The sequence is built from a 32-bit VLAN word, a 32-bit host-tag word and a 16-bit sequence word. It can also remove an existing 4-byte VLAN tag. The tag is removed only when the tag's type identifier equals a programmable 16-bit compare value.

The command is one-shot. A write to the command port arms an insertion mode and a strip request for exactly one frame. The first byte of the next frame takes a snapshot of the command and disarms it. A separate express flag in the command stays visible on `express_o` until the last byte of the frame leaves the block. A sticky status bit records each strip. The bit is cleared by a one-cycle clear pulse, which gives write-one-to-clear behaviour.

While inserted bytes are sent, the upstream side is stalled. While the candidate tag bytes are collected for the compare, the downstream side sees no valid bytes. If the frame ends inside the candidate tag, or the compare fails, the collected bytes are replayed unchanged.

Top module: `tag_edit_top`

## Requirements
- R1: After reset `out_valid_o` is 0, `strip_seen_o` is 0, `express_o` is 0, no command is armed and the type compare value is 16'h0081.
- R2: A frame sent with mode 0 and no strip request leaves the block with the same bytes, in the same order, with `out_last_o` on its final byte.
- R3: Mode 1 emits the 12 input bytes, then VLAN word bits [7:0], [15:8], [23:16], [31:24], then the rest of the frame.
- R4: Mode 2 emits the host-tag word low byte first and then the sequence word low byte first (6 bytes), directly after input byte 12.
- R5: Mode 3 emits the VLAN word, then the host-tag word, then the sequence word, each low byte first (10 bytes), directly after input byte 12.
- R6: The command acts on one frame only. A frame sent with no new command write passes unmodified.
- R7: When a strip is armed, input bytes 13 to 16 are removed if {byte 14, byte 13} equals the compare value and the frame has at least 17 bytes; `strip_seen_o` then becomes 1. Any insertion is placed before the stripped position.
- R8: When a strip is armed and {byte 14, byte 13} differs from the compare value, the frame is unchanged and `strip_seen_o` stays 0.
- R9: `strip_seen_o` stays 1 until a cycle with `stat_clr_i` high, which clears it.
- R10: A command write sets `express_o` to the written express bit. It returns to 0 after the handshake of the frame's last output byte.
- R11: A frame of 12 bytes or fewer gets no insertion. A frame that ends at or before byte 16 while a strip is armed is not stripped.
- R12: During insertion, `in_ready_o` is low for exactly one accepted output byte per inserted byte. A generated byte held under backpressure stays valid and stable.
- R13: Writing `tpid_we_i` replaces the compare value. Later strip decisions use the new value only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vlan_word_i | input | 32 | VLAN tag contents, sent low byte first |
| htag_word_i | input | 32 | Host-tag contents, sent low byte first |
| seq_word_i | input | 16 | Sequence contents, sent low byte first |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_mode_i | input | 2 | Insertion mode: 0 none, 1 VLAN, 2 host-tag+sequence, 3 all three |
| cmd_strip_i | input | 1 | Arm VLAN strip for the next frame |
| cmd_express_i | input | 1 | Express flag for the frame |
| tpid_we_i | input | 1 | Compare value write strobe |
| tpid_i | input | 16 | New compare value; bits [7:0] match byte 13 |
| stat_clr_i | input | 1 | Clear pulse for the strip status bit |
| strip_seen_o | output | 1 | Sticky: a strip happened |
| express_o | output | 1 | Express flag of the armed or current frame |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Input byte ends the frame |
| in_ready_o | output | 1 | Block accepts the input byte |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Output byte ends the frame |
| out_ready_i | input | 1 | Downstream accepts the output byte |

## Verification
A wrong internal state shows at the ports in two ways: the frame contents change, or the frame length changes. A bad insertion index or mode snapshot puts wrong bytes right after byte 12. A bad collect counter loses or repeats bytes 13 to 16, and a lost end marker merges two frames. All of these appear in the frame itself, before its last byte has left the block. A one-shot that fails to disarm shows up on the next frame, which comes out edited. Status errors show within a cycle or two of the frame end: a strip flag that is wrong or not sticky, or an express flag that never clears.

// File: rtl/tag_edit_pkg.sv
package tag_edit_pkg;

  typedef enum logic [1:0] {
    TM_NONE = 2'd0,
    TM_VLAN = 2'd1,
    TM_HTAG = 2'd2,
    TM_BOTH = 2'd3
  } tag_mode_e;

  typedef enum logic [1:0] {
    ST_PASS  = 2'd0,
    ST_INS   = 2'd1,
    ST_HOLD  = 2'd2,
    ST_FLUSH = 2'd3
  } ed_state_e;

  typedef struct packed {
    tag_mode_e mode;
    logic      strip;
    logic      express;
  } cmd_t;

endpackage

// File: rtl/tag_edit_cfg.sv
module tag_edit_cfg
  import tag_edit_pkg::*;
#(
  parameter int unsigned   TPID_W   = 16,
  parameter logic [TPID_W-1:0] TPID_RST = 'h0081
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  cmd_t              cmd_i,
  input  logic              frame_start_i,
  input  logic              frame_end_i,
  input  logic              tpid_we_i,
  input  logic [TPID_W-1:0] tpid_i,
  input  logic              strip_evt_i,
  input  logic              stat_clr_i,
  output cmd_t              armed_o,
  output logic [TPID_W-1:0] tpid_o,
  output logic              strip_seen_o
);

  tag_mode_e         mode_q;
  logic              strip_q, express_q, seen_q;
  logic [TPID_W-1:0] tpid_q;

  // one-shot: the write wins over the disarm at frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= TM_NONE;
      strip_q <= 1'b0;
    end else if (cmd_we_i) begin
      mode_q  <= cmd_i.mode;
      strip_q <= cmd_i.strip;
    end else if (frame_start_i) begin
      mode_q  <= TM_NONE;
      strip_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          express_q <= 1'b0;
    else if (cmd_we_i)    express_q <= cmd_i.express;
    else if (frame_end_i) express_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         seen_q <= 1'b0;
    else if (strip_evt_i) seen_q <= 1'b1;
    else if (stat_clr_i)  seen_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tpid_q <= TPID_RST;
    else if (tpid_we_i) tpid_q <= tpid_i;
  end

  assign armed_o      = '{mode: mode_q, strip: strip_q, express: express_q};
  assign tpid_o       = tpid_q;
  assign strip_seen_o = seen_q;

endmodule

// File: rtl/tag_edit_ins.sv
module tag_edit_ins
  import tag_edit_pkg::*;
#(
  parameter int unsigned TAG_W = 32,
  parameter int unsigned SEQ_W = 16,
  parameter int unsigned IDX_W = 4
) (
  input  tag_mode_e         mode_i,
  input  logic [TAG_W-1:0]  vlan_i,
  input  logic [TAG_W-1:0]  htag_i,
  input  logic [SEQ_W-1:0]  seq_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [7:0]        byte_o,
  output logic [IDX_W-1:0]  len_o
);

  localparam int unsigned TAG_B = TAG_W / 8;
  localparam int unsigned SEQ_B = SEQ_W / 8;
  localparam int unsigned MAX_B = 2 * TAG_B + SEQ_B;

  logic [7:0] pat [MAX_B];

  always_comb begin
    for (int k = 0; k < MAX_B; k++) pat[k] = 8'h00;
    len_o = '0;
    unique case (mode_i)
      TM_VLAN: begin
        for (int k = 0; k < TAG_B; k++) pat[k] = vlan_i[8*k +: 8];
        len_o = IDX_W'(TAG_B);
      end
      TM_HTAG: begin
        for (int k = 0; k < TAG_B; k++) pat[k] = htag_i[8*k +: 8];
        for (int k = 0; k < SEQ_B; k++) pat[TAG_B+k] = seq_i[8*k +: 8];
        len_o = IDX_W'(TAG_B + SEQ_B);
      end
      TM_BOTH: begin
        for (int k = 0; k < TAG_B; k++) pat[k] = vlan_i[8*k +: 8];
        for (int k = 0; k < TAG_B; k++) pat[TAG_B+k] = htag_i[8*k +: 8];
        for (int k = 0; k < SEQ_B; k++) pat[2*TAG_B+k] = seq_i[8*k +: 8];
        len_o = IDX_W'(MAX_B);
      end
      default: len_o = '0;
    endcase
  end

  always_comb begin
    byte_o = 8'h00;
    for (int k = 0; k < MAX_B; k++)
      if (idx_i == IDX_W'(k)) byte_o = pat[k];
  end

endmodule

// File: rtl/tag_edit_hold.sv
module tag_edit_hold #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned HEAD_B = 1,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                push_i,
  input  logic                clr_i,
  input  logic [7:0]          data_i,
  input  logic [CNT_W-1:0]    rd_idx_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [7:0]          rd_data_o,
  output logic [HEAD_B*8-1:0] head_o
);

  logic [7:0]       mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= 8'h00;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (push_i && cnt_q < CNT_W'(DEPTH)) begin
      for (int k = 0; k < DEPTH; k++)
        if (cnt_q == CNT_W'(k)) mem_q[k] <= data_i;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int k = 0; k < DEPTH; k++)
      if (rd_idx_i == CNT_W'(k)) rd_data_o = mem_q[k];
  end

  for (genvar g = 0; g < HEAD_B; g++) begin : g_head
    assign head_o[8*g +: 8] = mem_q[g];
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tag_edit_top.sv
module tag_edit_top
  import tag_edit_pkg::*;
#(
  parameter int unsigned HDR_BYTES = 12,
  parameter int unsigned TAG_W     = 32,
  parameter int unsigned SEQ_W     = 16,
  parameter int unsigned TPID_W    = 16,
  parameter logic [TPID_W-1:0] TPID_RST = 'h0081
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TAG_W-1:0]  vlan_word_i,
  input  logic [TAG_W-1:0]  htag_word_i,
  input  logic [SEQ_W-1:0]  seq_word_i,
  input  logic              cmd_we_i,
  input  logic [1:0]        cmd_mode_i,
  input  logic              cmd_strip_i,
  input  logic              cmd_express_i,
  input  logic              tpid_we_i,
  input  logic [TPID_W-1:0] tpid_i,
  input  logic              stat_clr_i,
  output logic              strip_seen_o,
  output logic              express_o,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  output logic              out_last_o,
  input  logic              out_ready_i
);

  localparam int unsigned TAG_B   = TAG_W / 8;
  localparam int unsigned SEQ_B   = SEQ_W / 8;
  localparam int unsigned TPID_B  = TPID_W / 8;
  localparam int unsigned INS_MAX = 2 * TAG_B + SEQ_B;
  localparam int unsigned IDX_W   = $clog2(INS_MAX + 1);
  localparam int unsigned HOLD_B  = TAG_B;
  localparam int unsigned HEAD_B  = TPID_B - 1;
  localparam int unsigned CNT_W   = $clog2(HOLD_B + 1);
  localparam int unsigned POS_W   = $clog2(HDR_BYTES + 1);

  ed_state_e          st_q, st_d;
  logic [POS_W-1:0]   pos_q, pos_d;
  logic [IDX_W-1:0]   ins_idx_q, ins_idx_d, ins_len;
  logic [CNT_W-1:0]   fl_idx_q, fl_idx_d, hold_cnt;
  logic               fl_last_q, fl_last_d;
  tag_mode_e          f_mode_q;
  logic               f_strip_q;
  cmd_t               cmd_wr, armed;
  tag_mode_e          armed_mode;
  logic               acc_in, acc_out, frame_start, frame_end;
  logic               strip_evt, hold_push, hold_clr, tpid_hit;
  logic [7:0]         ins_byte, hold_byte;
  logic [HEAD_B*8-1:0] hold_head;
  logic [TPID_W-1:0]  tpid_val;

  assign cmd_wr = '{mode: tag_mode_e'(cmd_mode_i), strip: cmd_strip_i, express: cmd_express_i};

  tag_edit_cfg #(.TPID_W(TPID_W), .TPID_RST(TPID_RST)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_we_i     (cmd_we_i),
    .cmd_i        (cmd_wr),
    .frame_start_i(frame_start),
    .frame_end_i  (frame_end),
    .tpid_we_i    (tpid_we_i),
    .tpid_i       (tpid_i),
    .strip_evt_i  (strip_evt),
    .stat_clr_i   (stat_clr_i),
    .armed_o      (armed),
    .tpid_o       (tpid_val),
    .strip_seen_o (strip_seen_o)
  );

  tag_edit_ins #(.TAG_W(TAG_W), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_ins (
    .mode_i(f_mode_q),
    .vlan_i(vlan_word_i),
    .htag_i(htag_word_i),
    .seq_i (seq_word_i),
    .idx_i (ins_idx_q),
    .byte_o(ins_byte),
    .len_o (ins_len)
  );

  tag_edit_hold #(.DEPTH(HOLD_B), .HEAD_B(HEAD_B), .CNT_W(CNT_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (hold_push),
    .clr_i    (hold_clr),
    .data_i   (in_data_i),
    .rd_idx_i (fl_idx_q),
    .cnt_o    (hold_cnt),
    .rd_data_o(hold_byte),
    .head_o   (hold_head)
  );

  assign armed_mode  = armed.mode;
  assign express_o   = armed.express;
  assign acc_in      = in_valid_i & in_ready_o;
  assign acc_out     = out_valid_o & out_ready_i;
  assign frame_start = acc_in && (st_q == ST_PASS) && (pos_q == '0);
  assign frame_end   = acc_out && out_last_o;
  // type field: byte 13 is the low byte of the compare value
  assign tpid_hit    = ({in_data_i, hold_head} == tpid_val);

  always_comb begin
    out_valid_o = 1'b0;
    out_data_o  = 8'h00;
    out_last_o  = 1'b0;
    in_ready_o  = 1'b0;
    unique case (st_q)
      ST_PASS: begin
        out_valid_o = in_valid_i;
        out_data_o  = in_data_i;
        out_last_o  = in_last_i;
        in_ready_o  = out_ready_i;
      end
      ST_INS: begin
        out_valid_o = 1'b1;
        out_data_o  = ins_byte;
      end
      ST_HOLD: in_ready_o = 1'b1;
      ST_FLUSH: begin
        out_valid_o = 1'b1;
        out_data_o  = hold_byte;
        out_last_o  = fl_last_q && (fl_idx_q == hold_cnt - CNT_W'(1));
      end
      default: ;
    endcase
  end

  always_comb begin
    st_d      = st_q;
    pos_d     = pos_q;
    ins_idx_d = ins_idx_q;
    fl_idx_d  = fl_idx_q;
    fl_last_d = fl_last_q;
    strip_evt = 1'b0;
    hold_push = 1'b0;
    hold_clr  = 1'b0;
    unique case (st_q)
      ST_PASS: if (acc_in) begin
        if (in_last_i) begin
          pos_d = '0;
        end else if (pos_q == POS_W'(HDR_BYTES - 1)) begin
          pos_d = POS_W'(HDR_BYTES);
          if (ins_len != '0) begin
            st_d      = ST_INS;
            ins_idx_d = '0;
          end else if (f_strip_q) begin
            st_d = ST_HOLD;
          end
        end else if (pos_q < POS_W'(HDR_BYTES)) begin
          pos_d = pos_q + 1'b1;
        end
      end
      ST_INS: if (acc_out) begin
        if (ins_idx_q == ins_len - IDX_W'(1)) begin
          ins_idx_d = '0;
          st_d      = f_strip_q ? ST_HOLD : ST_PASS;
        end else begin
          ins_idx_d = ins_idx_q + 1'b1;
        end
      end
      ST_HOLD: if (acc_in) begin
        if (in_last_i) begin
          // frame ended inside the candidate tag: replay it
          hold_push = 1'b1;
          fl_last_d = 1'b1;
          fl_idx_d  = '0;
          pos_d     = '0;
          st_d      = ST_FLUSH;
        end else if (hold_cnt == CNT_W'(TPID_B - 1) && !tpid_hit) begin
          hold_push = 1'b1;
          fl_last_d = 1'b0;
          fl_idx_d  = '0;
          st_d      = ST_FLUSH;
        end else if (hold_cnt == CNT_W'(HOLD_B - 1)) begin
          hold_clr  = 1'b1;
          strip_evt = 1'b1;
          st_d      = ST_PASS;
        end else begin
          hold_push = 1'b1;
        end
      end
      ST_FLUSH: if (acc_out) begin
        if (fl_idx_q == hold_cnt - CNT_W'(1)) begin
          hold_clr = 1'b1;
          fl_idx_d = '0;
          st_d     = ST_PASS;
        end else begin
          fl_idx_d = fl_idx_q + 1'b1;
        end
      end
      default: st_d = ST_PASS;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_PASS;
      pos_q     <= '0;
      ins_idx_q <= '0;
      fl_idx_q  <= '0;
      fl_last_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      pos_q     <= pos_d;
      ins_idx_q <= ins_idx_d;
      fl_idx_q  <= fl_idx_d;
      fl_last_q <= fl_last_d;
    end
  end

  // per-frame snapshot of the armed command
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_mode_q  <= TM_NONE;
      f_strip_q <= 1'b0;
    end else if (frame_start) begin
      f_mode_q  <= armed.mode;
      f_strip_q <= armed.strip;
    end
  end

endmodule

// File: rtl/tag_edit_chk.sv
module tag_edit_chk
  import tag_edit_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_ready_o,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_data_o,
  input logic       out_last_o,
  input logic       cmd_we_i,
  input logic       stat_clr_i,
  input logic       strip_seen_o,
  input logic       express_o,
  input logic       strip_evt_i,
  input logic       frame_start_i,
  input tag_mode_e  armed_mode_i,
  input ed_state_e  st_i
);

  p_sticky_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strip_seen_o && !stat_clr_i |=> strip_seen_o);

  p_sticky_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr_i && !strip_evt_i |=> !strip_seen_o);

  p_strip_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strip_evt_i |=> strip_seen_o);

  p_express_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o && !cmd_we_i |=> !express_o);

  p_oneshot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && !cmd_we_i |=> armed_mode_i == TM_NONE);

  p_gen_stable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_INS || st_i == ST_FLUSH) && out_valid_o && !out_ready_i
    |=> out_valid_o && $stable(out_data_o));

  p_ins_stall_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && st_i == ST_INS |=> !in_ready_o);

endmodule

bind tag_edit_top tag_edit_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_ready_o   (in_ready_o),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_data_o   (out_data_o),
  .out_last_o   (out_last_o),
  .cmd_we_i     (cmd_we_i),
  .stat_clr_i   (stat_clr_i),
  .strip_seen_o (strip_seen_o),
  .express_o    (express_o),
  .strip_evt_i  (strip_evt),
  .frame_start_i(frame_start),
  .armed_mode_i (armed_mode),
  .st_i         (st_q)
);

// File: tb/tag_edit_top_bench.sv
`timescale 1ns/1ps
module tag_edit_top_bench;

  localparam logic [31:0] VLAN = 32'hA1B2C3D4;
  localparam logic [31:0] HTAG = 32'h55667788;
  localparam logic [15:0] SEQ  = 16'h9ABC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0, cmd_strip = 1'b0, cmd_express = 1'b0;
  logic [1:0]  cmd_mode = 2'd0;
  logic        tpid_we = 1'b0, stat_clr = 1'b0;
  logic [15:0] tpid_w = 16'h0;
  logic        strip_seen, express;
  logic        in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0]  in_data = 8'h0;
  logic        out_valid, out_last;
  logic [7:0]  out_data;
  logic        out_ready = 1'b1;

  int          checks = 0, errors = 0;
  logic [15:0] cur_tpid = 16'h0081;
  logic [7:0]  in_b  [0:63];
  logic [7:0]  exp_b [0:63];
  logic [7:0]  got_b [0:127];
  int          got_n = 0, stall = 0, seed = 0;
  bit          done = 1'b0, bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  tag_edit_top u_tag_edit_top (
    .clk_i(clk), .rst_ni(rst_n),
    .vlan_word_i(VLAN), .htag_word_i(HTAG), .seq_word_i(SEQ),
    .cmd_we_i(cmd_we), .cmd_mode_i(cmd_mode), .cmd_strip_i(cmd_strip),
    .cmd_express_i(cmd_express), .tpid_we_i(tpid_we), .tpid_i(tpid_w),
    .stat_clr_i(stat_clr), .strip_seen_o(strip_seen), .express_o(express),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_last_o(out_last), .out_ready_i(out_ready)
  );

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_en ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    if (out_valid && out_ready) begin
      if (got_n < 128) got_b[got_n] = out_data;
      got_n++;
      if (out_last) done = 1'b1;
    end
    if (in_valid && !in_ready && out_ready) stall++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ins_len(input int m);
    case (m)
      1: return 4;
      2: return 6;
      3: return 10;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] tag_byte(input int m, input int k);
    if (m == 1) return VLAN[8*k +: 8];
    if (m == 2) return (k < 4) ? HTAG[8*k +: 8] : SEQ[8*(k-4) +: 8];
    if (k < 4) return VLAN[8*k +: 8];
    if (k < 8) return HTAG[8*(k-4) +: 8];
    return SEQ[8*(k-8) +: 8];
  endfunction

  // pat: 0 = foreign type bytes, 1 = current compare value, 2 = 0x81,0x00
  task automatic run_frame(input bit cmd_en, input int mode, input bit strip, input int pat,
                           input int len, input bit bp, input bit expr, input string tag);
    int n, il, em, t, mism;
    bit es, do_strip, acc;
    logic [15:0] key;
    string req;
    em = cmd_en ? mode : 0;
    es = cmd_en ? strip : 1'b0;
    seed++;
    for (int i = 1; i <= len; i++) in_b[i] = 8'(seed * 5 + i * 17);
    if (len >= 14) begin
      if (pat == 1) begin in_b[13] = cur_tpid[7:0]; in_b[14] = cur_tpid[15:8]; end
      else if (pat == 2) begin in_b[13] = 8'h81; in_b[14] = 8'h00; end
      else begin in_b[13] = 8'h12; in_b[14] = 8'h34; end
    end
    key = (len >= 14) ? {in_b[14], in_b[13]} : 16'h0;
    do_strip = es && len >= 17 && key == cur_tpid;
    il = (len > 12) ? ins_len(em) : 0;
    n = 0;
    for (int i = 1; i <= len && i <= 12; i++) begin exp_b[n] = in_b[i]; n++; end
    for (int k = 0; k < il; k++) begin exp_b[n] = tag_byte(em, k); n++; end
    for (int i = 13; i <= len; i++)
      if (!(do_strip && i <= 16)) begin exp_b[n] = in_b[i]; n++; end
    if (tag != "") req = tag;
    else if (!cmd_en) req = "R6";
    else if (do_strip) req = "R7";
    else if (len <= 12 || (es && len < 17 && key == cur_tpid)) req = "R11";
    else if (es) req = "R8";
    else req = (em == 0) ? "R2" : (em == 1) ? "R3" : (em == 2) ? "R4" : "R5";

    @(posedge clk); #1;
    cmd_we = cmd_en; cmd_mode = 2'(mode); cmd_strip = strip; cmd_express = expr;
    stat_clr = 1'b1;
    @(posedge clk); #1;
    cmd_we = 1'b0; stat_clr = 1'b0;
    chk(strip_seen == 1'b0, "R9", "status after clear", strip_seen, 0);
    if (cmd_en) chk(express == expr, "R10", "express after write", express, expr);
    bp_en = bp; got_n = 0; stall = 0; done = 1'b0;
    for (int i = 1; i <= len; i++) begin
      in_valid = 1'b1; in_data = in_b[i]; in_last = (i == len);
      do begin
        @(negedge clk); acc = in_ready;
        @(posedge clk); #1;
      end while (!acc);
    end
    in_valid = 1'b0; in_last = 1'b0;
    t = 0;
    while (!done && t < 400) begin @(posedge clk); t++; end
    @(posedge clk); #1;
    bp_en = 1'b0;
    mism = -1;
    for (int i = 0; i < n && i < got_n; i++) if (got_b[i] !== exp_b[i] && mism < 0) mism = i;
    chk(done, req, "frame end seen", done, 1);
    chk(got_n == n, req, "output length", got_n, n);
    chk(mism < 0, req, "first bad byte index", mism, -1);
    if (mism >= 0) $display("FAIL %s byte %0d: actual %0h expected %0h", req, mism, got_b[mism], exp_b[mism]);
    repeat (2) @(posedge clk); #1;
    chk(strip_seen == do_strip, do_strip ? "R7" : "R8", "strip status", strip_seen, do_strip);
    chk(express == 1'b0, "R10", "express after frame end", express, 0);
    if (!es) chk(stall == il, "R12", "input stall cycles", stall, il);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lens [8];
    lens = '{8, 12, 13, 14, 15, 16, 17, 22};
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(strip_seen == 1'b0, "R1", "strip status in reset", strip_seen, 0);
    chk(express == 1'b0, "R1", "express in reset", express, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready idle", in_ready, 1);
    // unarmed frame right after reset
    run_frame(1'b0, 0, 1'b1, 2, 20, 1'b0, 1'b0, "R1");
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 3; p += 2)
          for (int li = 0; li < 8; li++)
            for (int b = 0; b < 2; b++) begin
              run_frame(1'b1, m, s[0], p == 2 ? 1 : 0, lens[li], b[0], li[0], "");
              if (lens[li] == 22 && b == 0)
                run_frame(1'b0, 0, 1'b0, 1, 22, 1'b0, 1'b0, "R6");
            end
    // R13: new compare value
    @(posedge clk); #1;
    tpid_we = 1'b1; tpid_w = 16'h88A8;
    @(posedge clk); #1;
    tpid_we = 1'b0; cur_tpid = 16'h88A8;
    run_frame(1'b1, 1, 1'b1, 1, 20, 1'b0, 1'b1, "R13");
    run_frame(1'b1, 0, 1'b1, 2, 20, 1'b1, 1'b0, "R13");
    run_frame(1'b1, 3, 1'b1, 1, 24, 1'b1, 1'b0, "R13");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule